// File: doc/BRIEF.md
# Burst Read Initiator for a Shared Address/Data Bus

This block is the master side of a burst read on a bus whose address and data travel over the same lines. A local client gives it a start address, a four-bit command code, a set of byte-lane enables and a word count. The initiator then runs one transaction on the bus. The transaction has one address cycle and one turnaround cycle, followed by as many data phases as words were asked for. Each word the target delivers is stored in order in an internal buffer, which the client reads once the completion pulse appears.

The control lines are active low. The frame line marks that a transaction is in progress, and it goes high during the last data phase. The initiator-ready line stays low for every data phase. It is released in the cycle after the final word moves. The target has a fixed window in which to claim the transaction with its device-select line. If it does not, the initiator abandons the transfer and raises an abort flag together with the completion pulse.

Top module: `mbb_initiator`

## Requirements
- R1: In the cycle after a request is accepted (`req_valid` high while `req_ready` is high), `frame_n` is 0, `ad_oe` is 1, `ad_out` carries the request address, `cbe_n[3:0]` carries the 4-bit command code unchanged, and `req_ready` is 0.
- R2: The address is driven for exactly one cycle. In the next cycle `ad_oe` is 0, and it stays 0 for the rest of the transaction.
- R3: The cycle after the address cycle is a turnaround. In it `irdy_n` is 1 and `frame_n` is 0. From this cycle until the last word moves, `cbe_n` equals the inverted request byte enables, so a 0 on bit i enables byte lane i.
- R4: From the cycle after the turnaround, `irdy_n` is 0. A word is captured from `ad_in` at every rising edge where `irdy_n`, `trdy_n` and `devsel_n` are all 0. The k-th captured word (k counting from 0) lands in `rd_data[k*32 +: 32]`.
- R5: During data phases, `frame_n` is 1 exactly when one word remains to be transferred, and 0 while more than one remains.
- R6: In the cycle after the last word transfers, `irdy_n`, `frame_n` and every `cbe_n` bit are 1. `done` is 1 for that single cycle, `abort` is 0 and `rd_count` equals the requested length. `req_ready` is 1 in the following cycle.
- R7: If `devsel_n` is not 0 in any of the 5 cycles that follow the address cycle, the next cycle shows `frame_n` = 1, `irdy_n` = 1, `done` = 1, `abort` = 1 and `rd_count` = 0.
- R8: A `devsel_n` that first goes low in the 5th cycle after the address cycle still completes the burst normally, with no abort.
- R9: A request with length 0, or a length above 8, is ignored. `req_ready` stays 1 and `frame_n` stays 1 while it is held.
- R10: While reset is active, `req_ready` = 1, `frame_n` = 1, `irdy_n` = 1, `ad_oe` = 0, `done` = 0 and `rd_count` = 0.
- R11: A cycle with `trdy_n` = 1 captures nothing. `irdy_n` stays 0 through such wait states, and the word count does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client request strobe |
| req_ready | output | 1 | High while idle and able to take a request |
| req_addr | input | 32 | Start address of the burst |
| req_cmd | input | 4 | Command code driven in the address cycle |
| req_be | input | 4 | Byte-lane enables (active high) for the data phases |
| req_len | input | 4 | Number of words, 1 to 8 |
| frame_n | output | 1 | Transaction-in-progress line, active low |
| irdy_n | output | 1 | Initiator-ready line, active low |
| cbe_n | output | 4 | Command in the address cycle, inverted byte enables afterwards |
| ad_out | output | 32 | Value driven onto the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | 32 | Value seen on the shared lines |
| devsel_n | input | 1 | Target claim line, active low |
| trdy_n | input | 1 | Target-ready line, active low |
| done | output | 1 | One-cycle completion pulse |
| abort | output | 1 | High with `done` when the target never responded |
| rd_count | output | 4 | Number of words captured |
| rd_data | output | 256 | Captured words, word k in bits k*32+31 down to k*32 |

## Verification
Every burst length from 1 to 8 is run against every claim delay from 0 to 4 cycles. Each of these pairs is crossed with three target pacings: no wait states, a wait in every other cycle, and a wait in every third cycle. The length sweep shows whether the frame line is released in the correct phase, covering the case where the first phase is already the last. The delay sweep shows whether late claims that are still legal are accepted, with the 4-cycle delay exercising the last allowed cycle. The pacing sweep separates real captures from wait cycles and shows whether words land in the right buffer slots. Claim delays of 5 and 7 must end in an abort, and zero or oversized lengths must never start a transaction.

// File: rtl/mbb_pkg.sv
package mbb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_TURN,
        ST_DATA,
        ST_ENDS
    } mbb_state_e;
endpackage

// File: rtl/mbb_devsel_timer.sv
// Counts cycles without a target claim after the address cycle.
module mbb_devsel_timer #(
    parameter int TMO = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic watch,
    input  logic devsel_n,
    output logic expired
);
    localparam int CW = $clog2(TMO + 1);

    typedef struct packed {
        logic          seen;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (arm) begin
            d.seen = 1'b0;
            d.cnt  = '0;
        end else if (watch && !q.seen) begin
            if (!devsel_n) d.seen = 1'b1;
            else           d.cnt  = q.cnt + CW'(1);
        end
    end

    assign expired = watch && !q.seen && devsel_n && (q.cnt == CW'(TMO - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.seen <= 1'b0;
            q.cnt  <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/mbb_word_buf.sv
// Stores captured words in arrival order.
module mbb_word_buf #(
    parameter int DW   = 32,
    parameter int MAXW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [DW-1:0]        wr_data,
    output logic [$clog2(MAXW+1)-1:0] count,
    output logic [MAXW*DW-1:0]   data_flat
);
    localparam int LENW = $clog2(MAXW + 1);

    logic [LENW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)        cnt_d = '0;
        else if (wr_en) cnt_d = cnt_q + LENW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    for (genvar g = 0; g < MAXW; g++) begin : g_word
        logic [DW-1:0] w_d, w_q;
        always_comb begin
            w_d = w_q;
            if (wr_en && !clr && cnt_q == LENW'(g)) w_d = wr_data;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) w_q <= '0;
            else        w_q <= w_d;
        end
        assign data_flat[g*DW +: DW] = w_q;
    end
endmodule

// File: rtl/mbb_initiator.sv
// Burst read master for a bus with shared address/data lines.
module mbb_initiator
    import mbb_pkg::*;
#(
    parameter int DW   = 32,
    parameter int MAXW = 8,
    parameter int TMO  = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [DW-1:0]              req_addr,
    input  logic [3:0]                 req_cmd,
    input  logic [DW/8-1:0]            req_be,
    input  logic [$clog2(MAXW+1)-1:0]  req_len,
    output logic                       frame_n,
    output logic                       irdy_n,
    output logic [DW/8-1:0]            cbe_n,
    output logic [DW-1:0]              ad_out,
    output logic                       ad_oe,
    input  logic [DW-1:0]              ad_in,
    input  logic                       devsel_n,
    input  logic                       trdy_n,
    output logic                       done,
    output logic                       abort,
    output logic [$clog2(MAXW+1)-1:0]  rd_count,
    output logic [MAXW*DW-1:0]         rd_data
);
    localparam int BEW  = DW / 8;
    localparam int LENW = $clog2(MAXW + 1);

    typedef struct packed {
        mbb_state_e      st;
        logic            frame_n;
        logic            irdy_n;
        logic            ad_oe;
        logic [DW-1:0]   ad;
        logic [BEW-1:0]  cbe_n;
        logic [BEW-1:0]  be;
        logic [LENW-1:0] remain;
        logic            abort;
    } regs_t;

    regs_t q, d;
    logic  len_ok, accept, xfer, tmo_hit, watching;

    assign len_ok   = (req_len != '0) && (req_len <= LENW'(MAXW));
    assign watching = (q.st == ST_TURN) || (q.st == ST_DATA);
    assign xfer     = (q.st == ST_DATA) && !trdy_n && !devsel_n;

    mbb_devsel_timer #(.TMO(TMO)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (q.st == ST_ADDR),
        .watch    (watching),
        .devsel_n (devsel_n),
        .expired  (tmo_hit)
    );

    mbb_word_buf #(.DW(DW), .MAXW(MAXW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept),
        .wr_en     (xfer),
        .wr_data   (ad_in),
        .count     (rd_count),
        .data_flat (rd_data)
    );

    always_comb begin
        d      = q;
        accept = 1'b0;
        if (watching && tmo_hit) begin
            d.st      = ST_ENDS;
            d.frame_n = 1'b1;
            d.irdy_n  = 1'b1;
            d.cbe_n   = '1;
            d.abort   = 1'b1;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    if (req_valid && len_ok) begin
                        accept         = 1'b1;
                        d.st           = ST_ADDR;
                        d.frame_n      = 1'b0;
                        d.ad_oe        = 1'b1;
                        d.ad           = req_addr;
                        d.cbe_n        = '1;
                        d.cbe_n[3:0]   = req_cmd;
                        d.be           = req_be;
                        d.remain       = req_len;
                        d.abort        = 1'b0;
                    end
                end
                ST_ADDR: begin
                    d.st    = ST_TURN;
                    d.ad_oe = 1'b0;
                    d.ad    = '0;
                    d.cbe_n = ~q.be;
                end
                ST_TURN: begin
                    d.st      = ST_DATA;
                    d.irdy_n  = 1'b0;
                    d.frame_n = (q.remain == LENW'(1));
                end
                ST_DATA: begin
                    if (xfer) begin
                        if (q.remain == LENW'(1)) begin
                            d.st      = ST_ENDS;
                            d.irdy_n  = 1'b1;
                            d.frame_n = 1'b1;
                            d.cbe_n   = '1;
                            d.remain  = '0;
                        end else begin
                            d.remain  = q.remain - LENW'(1);
                            d.frame_n = (q.remain == LENW'(2));
                        end
                    end
                end
                ST_ENDS: d.st = ST_IDLE;
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.frame_n <= 1'b1;
            q.irdy_n  <= 1'b1;
            q.ad_oe   <= 1'b0;
            q.ad      <= '0;
            q.cbe_n   <= '1;
            q.be      <= '0;
            q.remain  <= '0;
            q.abort   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign frame_n   = q.frame_n;
    assign irdy_n    = q.irdy_n;
    assign cbe_n     = q.cbe_n;
    assign ad_out    = q.ad;
    assign ad_oe     = q.ad_oe;
    assign done      = (q.st == ST_ENDS);
    assign abort     = (q.st == ST_ENDS) && q.abort;
endmodule

// File: rtl/mbb_checker.sv
module mbb_checker (
    input logic clk,
    input logic rst_n,
    input logic frame_n,
    input logic irdy_n,
    input logic ad_oe,
    input logic trdy_n,
    input logic devsel_n,
    input logic done,
    input logic abort
);
    a_r1_frame_starts_with_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n) |-> ad_oe);

    a_r2_addr_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |=> !ad_oe);

    a_r3_turnaround_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |=> (irdy_n && !frame_n));

    a_r5_frame_up_before_irdy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irdy_n) |-> frame_n);

    a_r6_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (!irdy_n && frame_n && !trdy_n && !devsel_n) |=> (irdy_n && done));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_abort_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (done && frame_n && irdy_n));

    a_r11_wait_holds_irdy: assert property (@(posedge clk) disable iff (!rst_n)
        (!irdy_n && trdy_n && !frame_n) |=> !irdy_n || done);
endmodule

bind mbb_initiator mbb_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .ad_oe    (ad_oe),
    .trdy_n   (trdy_n),
    .devsel_n (devsel_n),
    .done     (done),
    .abort    (abort)
);

// File: tb/sim_mbb_initiator.sv
module sim_mbb_initiator;
    localparam int DW = 32, MAXW = 8, TMO = 5, BEW = 4, LENW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [DW-1:0] req_addr = '0;
    logic [3:0] req_cmd = '0;
    logic [BEW-1:0] req_be = '0;
    logic [LENW-1:0] req_len = '0;
    logic frame_n, irdy_n, ad_oe, done, abort;
    logic [BEW-1:0] cbe_n;
    logic [DW-1:0] ad_out;
    logic [DW-1:0] ad_in = '0;
    logic devsel_n = 1'b1;
    logic trdy_n = 1'b1;
    logic [LENW-1:0] rd_count;
    logic [MAXW*DW-1:0] rd_data;

    int errs = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mbb_initiator #(.DW(DW), .MAXW(MAXW), .TMO(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_cmd(req_cmd), .req_be(req_be), .req_len(req_len),
        .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .devsel_n(devsel_n), .trdy_n(trdy_n),
        .done(done), .abort(abort), .rd_count(rd_count), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] datum(input logic [31:0] a, input int k);
        return a ^ (32'h01010101 * k) ^ 32'h5A000000;
    endfunction

    task automatic burst(input logic [31:0] addr, input logic [3:0] cmd,
                         input logic [3:0] be, input int len, input int dly, input int wm);
        int got;
        bit fin;
        bit exp_abort;
        got = 0;
        fin = 1'b0;
        exp_abort = (dly >= TMO);
        @(negedge clk);
        req_addr = addr; req_cmd = cmd; req_be = be; req_len = LENW'(len);
        req_valid = 1'b1; devsel_n = 1'b1; trdy_n = 1'b1;
        @(negedge clk);
        // R1: address cycle
        chk(!frame_n && ad_oe && ad_out == addr && cbe_n == cmd && !req_ready,
            "R1", "address cycle", {frame_n, ad_oe, req_ready, cbe_n, ad_out[23:0]},
            {1'b0, 1'b1, 1'b0, cmd, addr[23:0]});
        req_valid = 1'b0;
        for (int c = 0; c < 80 && !fin; c++) begin
            @(negedge clk);
            if (c == 0) begin
                // R2, R3: turnaround
                chk(!ad_oe, "R2", "address released", ad_oe, 0);
                chk(irdy_n && !frame_n && cbe_n == ~be, "R3", "turnaround",
                    {irdy_n, frame_n, cbe_n}, {1'b1, 1'b0, ~be});
            end
            if (exp_abort && c == TMO) begin
                // R7: master abort
                chk(done && abort && frame_n && irdy_n && rd_count == 0, "R7", "abort cycle",
                    {done, abort, frame_n, irdy_n, rd_count}, {4'hF, 4'h0});
                fin = 1'b1;
            end else if (!exp_abort && got == len) begin
                // R6, R8: completion
                chk(done && !abort && irdy_n && frame_n && cbe_n == 4'hF && rd_count == LENW'(len),
                    (dly == TMO - 1) ? "R8" : "R6", "completion",
                    {done, abort, irdy_n, frame_n, cbe_n, rd_count},
                    {1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 4'(len)});
                for (int k = 0; k < len; k++)
                    chk(rd_data[k*DW +: DW] == datum(addr, k), "R4", "captured word",
                        rd_data[k*DW +: DW], datum(addr, k));
                fin = 1'b1;
            end else begin
                if (c >= 1 && !exp_abort) begin
                    // R4, R5, R11: data phase state
                    chk(!irdy_n && cbe_n == ~be, (got == 0) ? "R4" : "R11", "irdy in data phase",
                        {irdy_n, cbe_n}, {1'b0, ~be});
                    chk(frame_n == (len - got == 1), "R5", "frame in data phase",
                        frame_n, (len - got == 1));
                end
                if (exp_abort && c >= 1)
                    chk(!frame_n && !done, "R7", "waiting for claim", {frame_n, done}, 0);
                devsel_n = (c >= dly) ? 1'b0 : 1'b1;
                trdy_n = (!devsel_n && !(wm != 0 && (c % wm) == 0)) ? 1'b0 : 1'b1;
                ad_in = datum(addr, got);
                if (!irdy_n && !trdy_n && !devsel_n) got++;
            end
        end
        if (!fin) chk(1'b0, "R6", "burst never ended", 0, 1);
        devsel_n = 1'b1; trdy_n = 1'b1;
        @(negedge clk);
        chk(!done && req_ready && frame_n, "R6", "back to idle", {done, req_ready, frame_n}, 3'b011);
    endtask

    initial begin
        #(4 * 150000);
        chk(1'b0, "R6", "watchdog expired", 0, 1);
        if (!finished) begin
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(req_ready && frame_n && irdy_n && !ad_oe && !done && rd_count == 0, "R10", "reset state",
            {req_ready, frame_n, irdy_n, ad_oe, done, rd_count}, {5'b11100, 4'h0});
        rst_n = 1'b1;
        // R9: zero and oversized lengths are ignored
        for (int t = 0; t < 2; t++) begin
            @(negedge clk);
            req_len = (t == 0) ? 4'd0 : 4'd9; req_valid = 1'b1;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(req_ready && frame_n && !ad_oe, "R9", "illegal length ignored",
                    {req_ready, frame_n, ad_oe}, 3'b110);
            end
            req_valid = 1'b0;
        end
        for (int len = 1; len <= MAXW; len++)
            for (int dly = 0; dly < TMO; dly++)
                for (int w = 0; w < 3; w++)
                    burst(32'h1000_0000 + len * 256 + dly * 16 + w * 4,
                          (len % 2) ? 4'h6 : 4'h2, 4'(len * 3 + dly + w),
                          len, dly, (w == 0) ? 0 : w + 1);
        burst(32'hABCD_0040, 4'h6, 4'hF, 3, TMO, 0);
        burst(32'hABCD_0080, 4'h2, 4'h3, 5, TMO + 2, 2);
        burst(32'h0000_0100, 4'h6, 4'hF, 2, 0, 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule